// File: doc/BRIEF.md
# SDR SDRAM Command Monitor

This block watches the control bus of a single-data-rate SDRAM. It never drives the bus. On every rising clock edge it samples the clock-enable line, chip select, the three strobes, the bank select, the 13-bit address and the byte-mask lines. It then classifies what the controller issued.

One cycle after the sample, it emits a command pulse with a compact code. It keeps an open flag and the active row for each bank. It flags protocol misuse in sticky error bits and latches the mode-register opcode. It also turns the mask lines into byte enables, applying the write latency (zero clocks) and the read latency (two clocks).

The monitor is purely observing. It has no back-pressure path: it cannot stall the bus. It accepts exactly one command per clock and reports every accepted command with a one-cycle pulse, so a consumer of that pulse must take it in the cycle it appears. All status pins are plain levels.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: With chip select high, no command pulse is produced. With chip select low and all three strobes high, a pulse with code 0 (no-op) appears in the cycle after the sample.
- R2: With clock enable high and chip select low, the strobe pattern {ras_n,cas_n,we_n} maps to these codes: 011→1 (activate), 101→2 (read), 100→3 (write), 110→4 (burst stop), 010→5 (precharge), 001→6 (refresh), 000→7 (mode load). The pulse and code appear in the cycle after the sample. When no pulse is produced, the code reads 0.
- R3: An activate to a closed bank sets that bank's open flag and stores address bits 12..0 as its row. The row for bank b is at bits b*13+12..b*13 of the row output.
- R4: A read or write with address bit 10 high closes the addressed bank. With bit 10 low, the bank stays open.
- R5: A precharge with address bit 10 low closes only the addressed bank. With bit 10 high, it closes every bank and the bank select has no effect.
- R6: While clock enable is low, only the refresh pattern is accepted. It is reported as code 6 with the self-refresh flag high. Every other pattern gives no pulse and leaves bank state unchanged. A refresh with clock enable high reports code 6 with the flag low.
- R7: A mode load stores address bits 11..0 as the mode copy. If address bit 12 is high, a sticky warning is set.
- R8: The write byte enables equal the inverted mask lines in the same cycle, combinationally.
- R9: The read byte enables equal the inverted mask lines as sampled two clock edges earlier.
- R10: An activate to an open bank, or a read or write to a closed bank, sets a sticky protocol error. The error-bank output holds the bank of the first such offence. A rejected activate leaves the stored row unchanged.
- R11: A refresh (auto or self) while any bank is open sets a sticky refresh error.
- R12: A synchronous active-high reset closes all banks and clears both error bits, the warning, the mode copy and the command outputs. It also fills the read mask pipeline with masked values, so the read enables read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Sampled clock enable |
| cs_n_i | input | 1 | Chip select, low active |
| ras_n_i | input | 1 | Row strobe, low active |
| cas_n_i | input | 1 | Column strobe, low active |
| we_n_i | input | 1 | Write strobe, low active |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Address lines |
| dqm_i | input | 8 | Byte mask lines, high masks |
| cmd_valid_o | output | 1 | One-cycle pulse per accepted command |
| cmd_code_o | output | 3 | Command code (see R2) |
| cmd_sref_o | output | 1 | Refresh was a self-refresh entry |
| cmd_bank_o | output | 2 | Bank select of the reported command |
| bank_open_o | output | 4 | Open flag per bank |
| open_rows_o | output | 52 | Active row per bank, 13 bits each |
| mode_reg_o | output | 12 | Last mode opcode |
| mode_warn_o | output | 1 | Sticky: mode load had bit 12 high |
| proto_err_o | output | 1 | Sticky protocol error |
| err_bank_o | output | 2 | Bank of the first protocol error |
| refresh_err_o | output | 1 | Sticky refresh-with-open-bank error |
| wr_byte_en_o | output | 8 | Write byte enables, zero latency |
| rd_byte_en_o | output | 8 | Read byte enables, two-cycle latency |

## Verification
The bench builds the monitor with its defaults: four banks, 13-bit rows, a 12-bit mode field, eight mask lines and a read latency of two. Four banks let a single table walk hold two banks open at once. That walk can then show a single-bank precharge leaving the other bank alone, and a precharge-all clearing a mixed state. A latency of two puts a distinct mask value in each pipeline stage, so the bench can tell an enable that arrives one cycle early or late from a correct one.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_BST = 3'd4,
    CMD_PRE = 3'd5,
    CMD_REF = 3'd6,
    CMD_LMR = 3'd7
  } cmd_e;

  typedef struct packed {
    logic valid;
    cmd_e code;
    logic sref;
  } dec_t;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mon_pkg::*;
(
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output dec_t dec_o
);

  cmd_e raw;

  always_comb begin
    case ({ras_n_i, cas_n_i, we_n_i})
      3'b011:  raw = CMD_ACT;
      3'b101:  raw = CMD_RD;
      3'b100:  raw = CMD_WR;
      3'b110:  raw = CMD_BST;
      3'b010:  raw = CMD_PRE;
      3'b001:  raw = CMD_REF;
      3'b000:  raw = CMD_LMR;
      default: raw = CMD_NOP;
    endcase
  end

  always_comb begin
    dec_o.valid = 1'b0;
    dec_o.code  = CMD_NOP;
    dec_o.sref  = 1'b0;
    if (!cs_n_i) begin
      if (cke_i) begin
        dec_o.valid = 1'b1;
        dec_o.code  = raw;
      end else if (raw == CMD_REF) begin
        dec_o.valid = 1'b1;
        dec_o.code  = CMD_REF;
        dec_o.sref  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker #(
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             act_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i && !open_q) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;

  // R3
  act_opens_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    act_i |=> open_q);

  // R10
  act_open_keeps_row_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_i && open_q) |=> $stable(row_q));

  // R5
  close_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (close_i && !act_i) |=> !open_q);

endmodule

// File: rtl/sdr_mask_pipe.sv
module sdr_mask_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] dqm_i,
  output logic [W-1:0] wr_en_o,
  output logic [W-1:0] rd_en_o
);

  logic [W-1:0]  stg_q [DEPTH];
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= '1;
      fill_q <= '0;
    end else begin
      stg_q[0] <= dqm_i;
      for (int k = 1; k < DEPTH; k++) stg_q[k] <= stg_q[k-1];
      if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  assign wr_en_o = ~dqm_i;
  assign rd_en_o = ~stg_q[DEPTH-1];

  generate
    if (DEPTH == 2) begin : g_lat2_chk
      // R9
      rd_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_q == FW'(DEPTH)) |-> (rd_en_o == ~$past(dqm_i, 2)));
    end
  endgenerate

endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
  import sdr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int MODE_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int DQM_W     = 8,
  parameter int RD_LAT    = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       cke_i,
  input  logic                       cs_n_i,
  input  logic                       ras_n_i,
  input  logic                       cas_n_i,
  input  logic                       we_n_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  input  logic [DQM_W-1:0]           dqm_i,
  output logic                       cmd_valid_o,
  output logic [2:0]                 cmd_code_o,
  output logic                       cmd_sref_o,
  output logic [BA_W-1:0]            cmd_bank_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows_o,
  output logic [MODE_W-1:0]          mode_reg_o,
  output logic                       mode_warn_o,
  output logic                       proto_err_o,
  output logic [BA_W-1:0]            err_bank_o,
  output logic                       refresh_err_o,
  output logic [DQM_W-1:0]           wr_byte_en_o,
  output logic [DQM_W-1:0]           rd_byte_en_o
);

  dec_t dec;

  sdr_cmd_decode u_dec (
    .cke_i   (cke_i),
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .dec_o   (dec)
  );

  logic is_act, is_acc, is_pre, is_ref, is_lmr, ap, tgt_open, bad;
  logic [NUM_BANKS-1:0] bank_open, act_vec, close_vec;

  always_comb begin
    is_act   = dec.valid && (dec.code == CMD_ACT);
    is_acc   = dec.valid && ((dec.code == CMD_RD) || (dec.code == CMD_WR));
    is_pre   = dec.valid && (dec.code == CMD_PRE);
    is_ref   = dec.valid && (dec.code == CMD_REF);
    is_lmr   = dec.valid && (dec.code == CMD_LMR);
    ap       = addr_i[AP_BIT];
    tgt_open = bank_open[ba_i];
    bad      = (is_act && tgt_open) || (is_acc && !tgt_open);
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign act_vec[b]   = is_act && (ba_i == BA_W'(b));
      assign close_vec[b] = (is_pre && (ap || (ba_i == BA_W'(b)))) ||
                            (is_acc && ap && (ba_i == BA_W'(b)));
      sdr_bank_tracker #(.ROW_W(ROW_W)) u_trk (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .act_i   (act_vec[b]),
        .close_i (close_vec[b]),
        .row_i   (addr_i),
        .open_o  (bank_open[b]),
        .row_o   (open_rows_o[b*ROW_W +: ROW_W])
      );
    end
  endgenerate

  assign bank_open_o = bank_open;

  logic              cmd_valid_q, cmd_sref_q, proto_err_q, refresh_err_q, warn_q;
  cmd_e              cmd_code_q;
  logic [BA_W-1:0]   cmd_bank_q, err_bank_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmd_valid_q   <= 1'b0;
      cmd_code_q    <= CMD_NOP;
      cmd_sref_q    <= 1'b0;
      cmd_bank_q    <= '0;
      proto_err_q   <= 1'b0;
      err_bank_q    <= '0;
      refresh_err_q <= 1'b0;
      mode_q        <= '0;
      warn_q        <= 1'b0;
    end else begin
      cmd_valid_q <= dec.valid;
      cmd_code_q  <= dec.valid ? dec.code : CMD_NOP;
      cmd_sref_q  <= dec.sref;
      cmd_bank_q  <= ba_i;
      if (bad) begin
        proto_err_q <= 1'b1;
        if (!proto_err_q) err_bank_q <= ba_i;
      end
      if (is_ref && (|bank_open)) refresh_err_q <= 1'b1;
      if (is_lmr) begin
        mode_q <= addr_i[MODE_W-1:0];
        if (addr_i[MODE_W]) warn_q <= 1'b1;
      end
    end
  end

  assign cmd_valid_o   = cmd_valid_q;
  assign cmd_code_o    = cmd_code_q;
  assign cmd_sref_o    = cmd_sref_q;
  assign cmd_bank_o    = cmd_bank_q;
  assign proto_err_o   = proto_err_q;
  assign err_bank_o    = err_bank_q;
  assign refresh_err_o = refresh_err_q;
  assign mode_reg_o    = mode_q;
  assign mode_warn_o   = warn_q;

  sdr_mask_pipe #(.W(DQM_W), .DEPTH(RD_LAT)) u_mask (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .dqm_i   (dqm_i),
    .wr_en_o (wr_byte_en_o),
    .rd_en_o (rd_byte_en_o)
  );

  // R1
  inhibit_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cs_n_i |=> !cmd_valid_o);

  // R6
  cke_low_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cke_i && !(!cs_n_i && !ras_n_i && !cas_n_i && we_n_i)) |=> (!cmd_valid_o && $stable(bank_open_o)));

  // R10
  proto_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    proto_err_o |=> (proto_err_o && $stable(err_bank_o)));

  // R11
  refresh_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    refresh_err_o |=> refresh_err_o);

  // R5
  pre_all_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_pre && ap) |=> (bank_open_o == '0));

  // R12
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> ((bank_open_o == '0) && !proto_err_o && !refresh_err_o && !mode_warn_o));

endmodule

// File: tb/sdr_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdr_cmd_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1;
  logic        ras_n = 1'b1;
  logic        cas_n = 1'b1;
  logic        we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [7:0]  dqm = 8'hFF;

  logic        cmd_valid, cmd_sref, mode_warn, proto_err, refresh_err;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank, err_bank;
  logic [3:0]  bank_open;
  logic [51:0] open_rows;
  logic [11:0] mode_reg;
  logic [7:0]  wr_en, rd_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdr_cmd_monitor dut_i (
    .clk_i(clk), .rst_i(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr), .dqm_i(dqm),
    .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code), .cmd_sref_o(cmd_sref),
    .cmd_bank_o(cmd_bank), .bank_open_o(bank_open), .open_rows_o(open_rows),
    .mode_reg_o(mode_reg), .mode_warn_o(mode_warn), .proto_err_o(proto_err),
    .err_bank_o(err_bank), .refresh_err_o(refresh_err),
    .wr_byte_en_o(wr_en), .rd_byte_en_o(rd_en)
  );

  // stimulus [27]cke [26]cs_n [25:23]ras,cas,we [22:21]ba [20:8]addr
  // expected [7]valid [6:4]code [3:0]bank_open
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'b111, 2'd0, 13'h0000, 1'b1, 3'd0, 4'b0000},
    {1'b1, 1'b0, 3'b011, 2'd1, 13'h0ABC, 1'b1, 3'd1, 4'b0010},
    {1'b1, 1'b0, 3'b011, 2'd3, 13'h1FFF, 1'b1, 3'd1, 4'b1010},
    {1'b1, 1'b0, 3'b101, 2'd1, 13'h0005, 1'b1, 3'd2, 4'b1010},
    {1'b1, 1'b0, 3'b100, 2'd3, 13'h0407, 1'b1, 3'd3, 4'b0010},
    {1'b1, 1'b0, 3'b110, 2'd0, 13'h0000, 1'b1, 3'd4, 4'b0010},
    {1'b1, 1'b1, 3'b011, 2'd0, 13'h0000, 1'b0, 3'd0, 4'b0010},
    {1'b1, 1'b0, 3'b011, 2'd0, 13'h0000, 1'b1, 3'd1, 4'b0011},
    {1'b1, 1'b0, 3'b010, 2'd1, 13'h0000, 1'b1, 3'd5, 4'b0001},
    {1'b1, 1'b0, 3'b011, 2'd2, 13'h0123, 1'b1, 3'd1, 4'b0101},
    {1'b1, 1'b0, 3'b010, 2'd1, 13'h0400, 1'b1, 3'd5, 4'b0000},
    {1'b1, 1'b0, 3'b001, 2'd0, 13'h0000, 1'b1, 3'd6, 4'b0000},
    {1'b0, 1'b0, 3'b011, 2'd0, 13'h0000, 1'b0, 3'd0, 4'b0000},
    {1'b0, 1'b0, 3'b111, 2'd0, 13'h0000, 1'b0, 3'd0, 4'b0000},
    {1'b1, 1'b0, 3'b011, 2'd0, 13'h0007, 1'b1, 3'd1, 4'b0001},
    {1'b1, 1'b0, 3'b101, 2'd0, 13'h0400, 1'b1, 3'd2, 4'b0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a negedge, pass one posedge, return at the next negedge idle
  task automatic issue(input logic k, input logic c, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [12:0] a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 reset state",
        {cmd_valid, bank_open, proto_err, refresh_err, mode_warn, mode_reg, rd_en},
        {1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 12'h000, 8'h00});

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][27], VEC[i][26], VEC[i][25:23], VEC[i][22:21], VEC[i][20:8]);
      chk($sformatf("R1/R2/R3/R4/R5/R6 row %0d", i),
          {cmd_valid, cmd_code, bank_open}, VEC[i][7:0]);
    end
    chk("R10/R11 no false error", {proto_err, refresh_err}, 2'b00);

    // R3 row capture
    issue(1'b1, 1'b0, 3'b011, 2'd2, 13'h1234);
    chk("R3 row of bank2", open_rows[2*13 +: 13], 13'h1234);
    // R10 activate to open bank
    issue(1'b1, 1'b0, 3'b011, 2'd2, 13'h0555);
    chk("R10 act to open bank", {proto_err, err_bank}, {1'b1, 2'd2});
    chk("R10 row unchanged", open_rows[2*13 +: 13], 13'h1234);
    // R10 later offence keeps first bank
    issue(1'b1, 1'b0, 3'b101, 2'd0, 13'h0000);
    chk("R10 first bank held", {proto_err, err_bank}, {1'b1, 2'd2});
    // R11 refresh with bank2 open, R6 auto refresh flag low
    issue(1'b1, 1'b0, 3'b001, 2'd0, 13'h0000);
    chk("R11 refresh while open", refresh_err, 1'b1);
    chk("R6 auto refresh", {cmd_valid, cmd_code, cmd_sref}, {1'b1, 3'd6, 1'b0});
    // R6 self refresh entry
    issue(1'b0, 1'b0, 3'b001, 2'd0, 13'h0000);
    chk("R6 self refresh", {cmd_valid, cmd_code, cmd_sref}, {1'b1, 3'd6, 1'b1});
    // R7 mode load
    issue(1'b1, 1'b0, 3'b000, 2'd0, 13'h0033);
    chk("R7 mode load", {cmd_code, mode_reg, mode_warn}, {3'd7, 12'h033, 1'b0});
    issue(1'b1, 1'b0, 3'b000, 2'd0, 13'h1ABC);
    chk("R7 bit12 warning", {mode_reg, mode_warn}, {12'hABC, 1'b1});
    issue(1'b1, 1'b0, 3'b000, 2'd0, 13'h0001);
    chk("R7 warning sticky", {mode_reg, mode_warn}, {12'h001, 1'b1});

    // R8 write enables, zero latency
    dqm = 8'h0F;
    #1;
    chk("R8 write enable", wr_en, 8'hF0);
    // R9 read enables, two edges
    dqm = 8'hFF;
    repeat (3) @(negedge clk);
    dqm = 8'hA5;
    @(negedge clk);
    chk("R9 not after one edge", rd_en, 8'h00);
    dqm = 8'h3C;
    @(negedge clk);
    chk("R9 first value", rd_en, 8'h5A);
    dqm = 8'hFF;
    @(negedge clk);
    chk("R9 second value", rd_en, 8'hC3);

    // R12 reset clears sticky state
    do_reset();
    chk("R12 reset clears",
        {bank_open, proto_err, refresh_err, mode_warn, mode_reg, rd_en},
        {4'b0000, 1'b0, 1'b0, 1'b0, 12'h000, 8'h00});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule